// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block watches the live time and calendar of a real-time clock and raises an alarm when the stored alarm fields agree with it. It holds two alarm units. The first compares seconds, minutes, hours, date, month and day of week. The second compares minutes, hours and one extra byte that matches either the date or the day of week, as that byte itself selects. Every stored alarm byte carries its own enable in bit 7. Only fields whose enable is set take part in the comparison, so software can build alarms such as "every minute at second 30" or "every Monday at 08:10".

Comparison is done only on the cycle in which the one-second tick is high. The counters update before that tick, and the tick lasts one cycle, so a matching second fires once. A match sets a sticky per-alarm flag. Software clears a flag by writing 0 to its bit in the status location. An interrupt line is driven high while any flag is set and its own interrupt enable is on.

The time inputs and the register write port come from the surrounding clock logic. The counters and the bus interface are not part of this block.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After synchronous reset, every alarm byte is 00h (all fields disabled), both interrupt enables are 0, both flags are 0 and the interrupt line is low.
- R2: Alarm 1 bytes sit at write addresses 0 to 5 (seconds, minutes, hours, date, month, day of week). With the tick high and every enabled field equal to the live value, the alarm 1 flag is high from the next clock edge. A mismatch on any enabled field sets no flag.
- R3: A field whose byte has bit 7 clear takes no part in the match. Its stored value may differ from the live value.
- R4: An alarm with no field enabled never matches, even when all its stored values equal the live time.
- R5: With the tick low, no flag is set, whatever the time and alarm values are.
- R6: A flag stays set across later ticks whose time does not match.
- R7: A write to address 9 (status, bit 0 alarm 1, bit 1 alarm 2) clears each flag whose bit is written 0 and leaves a flag whose bit is written 1 unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R8: Address 10 holds the interrupt enables (bit 0 for alarm 1, bit 1 for alarm 2). The interrupt output is (flag1 AND enable1) OR (flag2 AND enable2), and it follows a change of either input with no added cycle.
- R9: Alarm 2 bytes sit at addresses 6 (minutes), 7 (hours) and 8 (day byte). When bit 6 of the day byte is 1, its bits 2:0 are compared with the day of week. When bit 6 is 0, its bits 5:0 are compared with the date.
- R10: Only value bits are compared: 7 bits for seconds and minutes, 6 for hours and date, 5 for month and 3 for day of week. Higher bits of the live inputs are ignored.
- R11: Writes to addresses 11 to 15 change neither alarm bytes, enables nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second, after the counters update |
| cur_sec | input | 8 | Live seconds, BCD |
| cur_min | input | 8 | Live minutes, BCD |
| cur_hour | input | 8 | Live hours, BCD, 24-hour |
| cur_date | input | 8 | Live date, BCD |
| cur_month | input | 8 | Live month, BCD |
| cur_dow | input | 8 | Live day of week, 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm1_flag | output | 1 | Sticky alarm 1 match flag |
| alarm2_flag | output | 1 | Sticky alarm 2 match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: one byte per field, a four-bit address and the six- and three-field alarm units. This brings every address, both day-byte modes of alarm 2 and the unused address range within reach. With these settings the bench can drive exact time values, including day-of-week inputs with stray high bits, a match that lands in the same cycle as a clearing write, and mixed enable patterns in a single short directed run.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int A1_N       = 6;
    localparam int A2_N       = 3;
    localparam int EN_BIT     = 7;
    localparam int A2_SEL_BIT = 6;
    localparam int NUM_ALARMS = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_A1_SEC   = 4'd0,
        RA_A1_MIN   = 4'd1,
        RA_A1_HOUR  = 4'd2,
        RA_A1_DATE  = 4'd3,
        RA_A1_MONTH = 4'd4,
        RA_A1_DOW   = 4'd5,
        RA_A2_MIN   = 4'd6,
        RA_A2_HOUR  = 4'd7,
        RA_A2_DAY   = 4'd8,
        RA_STATUS   = 4'd9,
        RA_CTRL     = 4'd10
    } reg_addr_e;

    localparam logic [ADDR_W-1:0] A2_BASE = RA_A2_MIN;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t date;
        byte_t month;
        byte_t dow;
    } cal_t;

    localparam byte_t MASK_SEC   = 8'h7F;
    localparam byte_t MASK_MIN   = 8'h7F;
    localparam byte_t MASK_HOUR  = 8'h3F;
    localparam byte_t MASK_DATE  = 8'h3F;
    localparam byte_t MASK_MONTH = 8'h1F;
    localparam byte_t MASK_DOW   = 8'h07;

    typedef struct packed {
        logic a1;
        logic a2;
    } irq_en_t;

    // a field passes when it is disabled or its value bits agree
    function automatic logic field_ok(byte_t alarm, byte_t live, byte_t mask);
        return !alarm[EN_BIT] || ((alarm & mask) == (live & mask));
    endfunction

    function automatic logic field_on(byte_t alarm);
        return alarm[EN_BIT];
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    output byte_t             a1_q [A1_N],
    output byte_t             a2_q [A2_N],
    output irq_en_t           ie_q
);

    for (genvar i = 0; i < A1_N; i++) begin : g_a1
        always_ff @(posedge clk) begin
            if (rst)
                a1_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                a1_q[i] <= wr_data;
        end
    end

    for (genvar j = 0; j < A2_N; j++) begin : g_a2
        always_ff @(posedge clk) begin
            if (rst)
                a2_q[j] <= '0;
            else if (wr_en && wr_addr == A2_BASE + ADDR_W'(j))
                a2_q[j] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ie_q <= '0;
        else if (wr_en && wr_addr == RA_CTRL)
            ie_q <= '{a1: wr_data[0], a2: wr_data[1]};
    end

    // R1: storage leaves reset cleared
    a_r1_regs_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a1_q[0] == '0 && a2_q[A2_N-1] == '0 && ie_q == '0));

endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int N = 3
) (
    input  logic  fire,
    input  byte_t alarm [N],
    input  byte_t live  [N],
    input  byte_t mask  [N],
    output logic  hit
);

    logic [N-1:0] ok;
    logic [N-1:0] on;

    for (genvar k = 0; k < N; k++) begin : g_field
        assign ok[k] = field_ok(alarm[k], live[k], mask[k]);
        assign on[k] = field_on(alarm[k]);
    end

    assign hit = fire && (&ok) && (|on);

endmodule

// File: rtl/alarm_status.sv
module alarm_status
    import rtc_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [NUM_ALARMS-1:0] hit,
    input  logic                  clr_wr,
    input  logic [NUM_ALARMS-1:0] clr_keep,
    input  irq_en_t               ie,
    output logic [NUM_ALARMS-1:0] flag,
    output logic                  irq
);

    logic [NUM_ALARMS-1:0] ie_vec;
    assign ie_vec = {ie.a2, ie.a1};

    for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag[n] <= 1'b0;
            else if (hit[n])
                flag[n] <= 1'b1;
            else if (clr_wr && !clr_keep[n])
                flag[n] <= 1'b0;
        end
    end

    assign irq = |(flag & ie_vec);

    // R5: a flag can only rise after a tick
    a_r5_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[0]) |-> $past(tick));

    // R6: a set flag with no clearing write stays set
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag[1] && !clr_wr) |=> flag[1]);

    // R7: clearing write without a match drops the flag
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !clr_keep[0] && !tick) |=> !flag[0]);

    // R8: interrupt implies some flag is set
    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag != '0));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [7:0]  cur_sec,
    input  logic [7:0]  cur_min,
    input  logic [7:0]  cur_hour,
    input  logic [7:0]  cur_date,
    input  logic [7:0]  cur_month,
    input  logic [7:0]  cur_dow,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        alarm1_flag,
    output logic        alarm2_flag,
    output logic        irq
);

    cal_t    now;
    byte_t   a1_q [A1_N];
    byte_t   a2_q [A2_N];
    irq_en_t ie_q;

    assign now = '{sec: cur_sec, min: cur_min, hour: cur_hour,
                   date: cur_date, month: cur_month, dow: cur_dow};

    alarm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .a1_q    (a1_q),
        .a2_q    (a2_q),
        .ie_q    (ie_q)
    );

    // alarm 1 lanes
    byte_t a1_live [A1_N];
    byte_t a1_mask [A1_N];
    assign a1_live = '{now.sec, now.min, now.hour, now.date, now.month, now.dow};
    assign a1_mask = '{MASK_SEC, MASK_MIN, MASK_HOUR, MASK_DATE, MASK_MONTH, MASK_DOW};

    // alarm 2 lanes, day byte picks date or day of week
    logic  day_sel;
    byte_t a2_alarm [A2_N];
    byte_t a2_live  [A2_N];
    byte_t a2_mask  [A2_N];
    byte_t day_byte;

    assign day_sel  = a2_q[2][A2_SEL_BIT];
    assign day_byte = {a2_q[2][EN_BIT], 1'b0, a2_q[2][5:0]};
    assign a2_alarm = '{a2_q[0], a2_q[1], day_byte};
    assign a2_live  = '{now.min, now.hour, day_sel ? now.dow : now.date};
    assign a2_mask  = '{MASK_MIN, MASK_HOUR, day_sel ? MASK_DOW : MASK_DATE};

    logic [NUM_ALARMS-1:0] hit;

    alarm_match #(.N(A1_N)) u_match1 (
        .fire  (tick),
        .alarm (a1_q),
        .live  (a1_live),
        .mask  (a1_mask),
        .hit   (hit[0])
    );

    alarm_match #(.N(A2_N)) u_match2 (
        .fire  (tick),
        .alarm (a2_alarm),
        .live  (a2_live),
        .mask  (a2_mask),
        .hit   (hit[1])
    );

    logic                  clr_wr;
    logic [NUM_ALARMS-1:0] flag;

    assign clr_wr = wr_en && (wr_addr == RA_STATUS);

    alarm_status u_status (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .hit      (hit),
        .clr_wr   (clr_wr),
        .clr_keep (wr_data[NUM_ALARMS-1:0]),
        .ie       (ie_q),
        .flag     (flag),
        .irq      (irq)
    );

    assign alarm1_flag = flag[0];
    assign alarm2_flag = flag[1];

    // R4: with every alarm 1 field disabled no match reaches the flag
    a_r4_idle_alarm: assert property (@(posedge clk) disable iff (rst)
        (tick && a1_q[0][7] == 1'b0 && a1_q[1][7] == 1'b0 && a1_q[2][7] == 1'b0 &&
         a1_q[3][7] == 1'b0 && a1_q[4][7] == 1'b0 && a1_q[5][7] == 1'b0 &&
         !alarm1_flag) |=> !alarm1_flag);

    // R2: a rising alarm 1 flag follows a tick whose enabled seconds agreed
    a_r2_sec_agrees: assert property (@(posedge clk) disable iff (rst)
        ($rose(alarm1_flag) && $past(a1_q[0][7])) |->
        ($past(cur_sec[6:0]) == $past(a1_q[0][6:0])));

endmodule

// File: tb/sim_rtc_alarm_unit.sv
`timescale 1ns/1ps
module sim_rtc_alarm_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [7:0] cur_date = '0, cur_month = '0, cur_dow = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       alarm1_flag, alarm2_flag, irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rtc_alarm_unit u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month), .cur_dow(cur_dow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm1_flag(alarm1_flag), .alarm2_flag(alarm2_flag), .irq(irq)
    );

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // one cycle of stimulus, outputs sampled at the following negedge
    task automatic step(logic w, logic [3:0] a, logic [7:0] d, logic t);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic tk();
        step(1'b0, 4'd0, 8'd0, 1'b1);
    endtask

    task automatic set_time(logic [7:0] s, m, h, d, mo, w);
        cur_sec = s; cur_min = m; cur_hour = h;
        cur_date = d; cur_month = mo; cur_dow = w;
    endtask

    task automatic t_reset();
        check("R1 flag1", alarm1_flag, 1'b0);
        check("R1 flag2", alarm2_flag, 1'b0);
        check("R1 irq", irq, 1'b0);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        tk();
        check("R1 bytes disabled flag1", alarm1_flag, 1'b0);
        check("R1 bytes disabled flag2", alarm2_flag, 1'b0);
    endtask

    task automatic t_a1_full();
        wr(4'd0, 8'hC5); wr(4'd1, 8'hB0); wr(4'd2, 8'h93);
        wr(4'd3, 8'hA1); wr(4'd4, 8'h87); wr(4'd5, 8'h84);
        set_time(8'h45, 8'h30, 8'h13, 8'h21, 8'h07, 8'h04);
        repeat (3) @(negedge clk);
        check("R5 no tick no flag", alarm1_flag, 1'b0);
        tk();
        check("R2 all fields match", alarm1_flag, 1'b1);
        check("R8 irq off when disabled", irq, 1'b0);
        cur_sec = 8'h46;
        tk();
        check("R6 flag sticky", alarm1_flag, 1'b1);
        wr(4'd9, 8'h02);
        check("R7 clear flag1", alarm1_flag, 1'b0);
        tk();
        check("R2 seconds mismatch", alarm1_flag, 1'b0);
    endtask

    task automatic t_masked_field();
        wr(4'd0, 8'h45);
        tk();
        check("R3 disabled field ignored", alarm1_flag, 1'b1);
        wr(4'd9, 8'h00);
        for (int i = 0; i < 6; i++) wr(4'(i), 8'h00);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        tk();
        check("R4 no field enabled", alarm1_flag, 1'b0);
        wr(4'd0, 8'h45);
        cur_sec = 8'h45;
        tk();
        check("R4 values equal but disabled", alarm1_flag, 1'b0);
    endtask

    task automatic t_width();
        for (int i = 0; i < 6; i++) wr(4'(i), 8'h00);
        wr(4'd5, 8'h83);
        cur_dow = 8'hF3;
        tk();
        check("R10 dow high bits ignored", alarm1_flag, 1'b1);
        wr(4'd5, 8'h00);
        wr(4'd4, 8'h92);
        cur_month = 8'hF2;
        wr(4'd9, 8'h00);
        tk();
        check("R10 month high bits ignored", alarm1_flag, 1'b1);
        wr(4'd4, 8'h00);
        wr(4'd9, 8'h00);
    endtask

    task automatic t_a2();
        wr(4'd6, 8'h90); wr(4'd7, 8'h88); wr(4'd8, 8'hC3);
        set_time(8'h00, 8'h10, 8'h08, 8'h05, 8'h01, 8'h03);
        tk();
        check("R9 dow mode match", alarm2_flag, 1'b1);
        check("R9 alarm1 untouched", alarm1_flag, 1'b0);
        wr(4'd9, 8'h01);
        check("R7 clear flag2 bit1=0", alarm2_flag, 1'b0);
        set_time(8'h00, 8'h10, 8'h08, 8'h03, 8'h01, 8'h05);
        tk();
        check("R9 dow mode mismatch", alarm2_flag, 1'b0);
        wr(4'd8, 8'h85);
        set_time(8'h00, 8'h10, 8'h08, 8'h05, 8'h01, 8'h03);
        tk();
        check("R9 date mode match", alarm2_flag, 1'b1);
        wr(4'd9, 8'h00);
        set_time(8'h00, 8'h10, 8'h08, 8'h03, 8'h01, 8'h05);
        tk();
        check("R9 date mode mismatch", alarm2_flag, 1'b0);
    endtask

    task automatic t_irq_and_race();
        set_time(8'h00, 8'h10, 8'h08, 8'h05, 8'h01, 8'h03);
        tk();
        check("R8 flag2 set", alarm2_flag, 1'b1);
        wr(4'd10, 8'h01);
        check("R8 irq gated by enable2", irq, 1'b0);
        wr(4'd10, 8'h02);
        check("R8 irq from flag2", irq, 1'b1);
        step(1'b1, 4'd9, 8'h00, 1'b1);
        check("R7 match beats clear", alarm2_flag, 1'b1);
        wr(4'd9, 8'h02);
        check("R7 bit1=1 keeps flag2", alarm2_flag, 1'b1);
    endtask

    task automatic t_unused();
        for (int a = 11; a < 16; a++) wr(4'(a), 8'h00);
        check("R11 flag2 kept", alarm2_flag, 1'b1);
        check("R11 irq enable kept", irq, 1'b1);
        for (int a = 11; a < 16; a++) wr(4'(a), 8'hFF);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        tk();
        check("R11 no alarm1 created", alarm1_flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_a1_full();
        t_masked_field();
        t_width();
        t_a2();
        t_irq_and_race();
        t_unused();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule